// File: doc/BRIEF.md
# Pipelined CORDIC Trigonometry Unit

This block evaluates sine, cosine and two-argument arctangent on 32-bit fixed-point operands. It uses shift-and-add CORDIC iterations. Each of the 32 iterations has its own register stage, so the unit takes a new operand set on every clock. The matching result leaves the far end a fixed 32 clocks later. Where several units are chained, their latencies add.

A mode bit chooses between two operations:

- **Rotation** turns a gain-compensated unit vector through the supplied angle and returns the cosine and sine of that angle.
- **Vectoring** turns the supplied (x, y) vector onto the positive x axis. It returns the angle swept, which is the arctangent of y over x taken over all four quadrants, together with the gain-scaled vector length.

Before the first iteration, a combinational fold brings every argument into the half plane where the iterations converge.

Top module: `cordic_pipe`

## Requirements
- R1: A sample accepted with `in_valid` high at a rising edge appears with `out_valid` high exactly 32 rising edges later. Back-to-back samples give back-to-back results, one per clock.
- R2: While `rst_n` is low, `out_valid` is low.
- R3: In rotation mode (`in_mode` = 0), `out_x` is the cosine and `out_y` is the sine of `in_angle`, each within 64 LSB.
  - The sine and cosine are signed with 30 fraction bits, so 1.0 is 2^30.
  - The angle is a 32-bit two's-complement value in which 2^32 is one full turn, so 0x40000000 is a quarter turn.
- R4: In rotation mode, `out_angle` returns the residual angle, which lies within 64 LSB of zero.
- R5: Rotation angles in the second and third quadrants are correct. This includes exactly +90, +180 (0x80000000) and values just past -90 degrees. These angles are folded by a half turn before the iterations.
- R6: In rotation mode, `in_x` and `in_y` have no effect on any output.
- R7: In vectoring mode (`in_mode` = 1), for an input vector of length below 1.0, the unit returns three results:
  - `out_angle` equals atan2(`in_y`, `in_x`) in the turn encoding, modulo 2^32, within 64 LSB.
  - `out_x` equals 1.6467602 times the vector length, within 64 LSB.
  - `out_y` is within 64 LSB of zero.
- R8: Vectoring inputs with negative `in_x` are correct, including the case where `in_y` is exactly zero, which gives a half turn (0x80000000). These inputs are negated and seeded with a half turn before the iterations.
- R9: `out_mode` equals the `in_mode` of the sample it belongs to. The mode may change on every clock.
- R10: A clock with `in_valid` low produces a clock with `out_valid` low 32 edges later, whatever the data inputs carry.
- R11: For legal operands, the internal x and y results fit the 32-bit outputs without wrapping. This holds up to a vectoring length of 0.99.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Operand set present this clock |
| in_mode | input | 1 | 0 = rotation, 1 = vectoring |
| in_x | input | 32 | Vector x component, signed, 30 fraction bits (vectoring only) |
| in_y | input | 32 | Vector y component, signed, 30 fraction bits (vectoring only) |
| in_angle | input | 32 | Angle, 2^32 per turn (rotation only) |
| out_valid | output | 1 | Result present this clock |
| out_mode | output | 1 | Mode of the returned sample |
| out_x | output | 32 | Cosine (rotation) or scaled length (vectoring) |
| out_y | output | 32 | Sine (rotation) or residual y (vectoring) |
| out_angle | output | 32 | Residual angle (rotation) or atan2 (vectoring) |

## Verification
The hardest conditions to reach are on the boundaries of the pre-iteration fold:

- rotation angles on the exact quadrant edges, where the top two angle bits change;
- vectoring inputs on the negative x axis, where the seeded half turn must survive 32 iterations that alternate direction around a zero y.

A random sweep rarely lands on these boundaries, so the stimulus names them directly. It then interleaves the two modes on alternate clocks and inserts idle clocks carrying garbage operands, so that mode and valid are shown to travel with their own sample. A behavioural model in real arithmetic compares every output clock.

// File: rtl/cordic_pipe_pkg.sv
package cordic_pipe_pkg;

  typedef enum logic {
    MODE_ROTATE = 1'b0,
    MODE_VECTOR = 1'b1
  } cmode_e;

  // Reciprocal CORDIC gain, 30 fraction bits.
  localparam logic [31:0] INV_GAIN_Q30 = 32'h26DD3B6A;

  // Elementary angle atan(2^-idx), expressed with 2^32 units per turn.
  function automatic logic [31:0] atan_turn32(input int idx);
    case (idx)
      0:  return 32'h20000000;
      1:  return 32'h12E4051E;
      2:  return 32'h09FB385B;
      3:  return 32'h051111D4;
      4:  return 32'h028B0D43;
      5:  return 32'h0145D7E1;
      6:  return 32'h00A2F61E;
      7:  return 32'h00517C55;
      8:  return 32'h0028BE53;
      9:  return 32'h00145F2F;
      10: return 32'h000A2F98;
      11: return 32'h000517CC;
      12: return 32'h00028BE6;
      13: return 32'h000145F3;
      14: return 32'h0000A2F9;
      15: return 32'h0000517C;
      16: return 32'h000028BE;
      17: return 32'h0000145F;
      18: return 32'h00000A30;
      19: return 32'h00000518;
      20: return 32'h0000028C;
      21: return 32'h00000146;
      22: return 32'h000000A3;
      23: return 32'h00000051;
      24: return 32'h00000029;
      25: return 32'h00000014;
      26: return 32'h0000000A;
      27: return 32'h00000005;
      28: return 32'h00000003;
      29: return 32'h00000001;
      30: return 32'h00000001;
      default: return 32'h00000000;
    endcase
  endfunction

  // Move a 32-bit based constant to another scale; shl may be negative.
  function automatic logic signed [63:0] rescale(input logic [31:0] v, input int shl);
    if (shl >= 0) return $signed({32'd0, v}) <<< shl;
    else return $signed({32'd0, v}) >>> (-shl);
  endfunction

endpackage

// File: rtl/cordic_pipe_fold.sv
module cordic_pipe_fold
  import cordic_pipe_pkg::*;
#(
  parameter int W     = 32,
  parameter int GUARD = 4,
  parameter int IW    = W + 2 + GUARD
) (
  input  cmode_e                 mode_i,
  input  logic [W-1:0]           x_i,
  input  logic [W-1:0]           y_i,
  input  logic [W-1:0]           angle_i,
  output logic signed [IW-1:0]   x_o,
  output logic signed [IW-1:0]   y_o,
  output logic [W-1:0]           z_o
);

  localparam logic signed [IW-1:0] X_SEED    = IW'(rescale(INV_GAIN_Q30, W - 32 + GUARD));
  localparam logic [W-1:0]         HALF_TURN = {1'b1, {(W-1){1'b0}}};

  // Sign-extend to the internal width and append the guard bits.
  function automatic logic signed [IW-1:0] widen(input logic [W-1:0] v);
    return {{(IW-W-GUARD){v[W-1]}}, v, {GUARD{1'b0}}};
  endfunction

  // True when the angle lies outside [-quarter, +quarter).
  function automatic logic past_quarter(input logic [W-1:0] a);
    return a[W-1] ^ a[W-2];
  endfunction

  logic                  flip;
  logic signed [IW-1:0]  xw, yw;

  always_comb begin
    xw = widen(x_i);
    yw = widen(y_i);
    if (mode_i == MODE_ROTATE) begin
      flip = past_quarter(angle_i);
      x_o  = flip ? -X_SEED : X_SEED;
      y_o  = '0;
      z_o  = flip ? angle_i + HALF_TURN : angle_i;
    end else begin
      flip = x_i[W-1];
      x_o  = flip ? -xw : xw;
      y_o  = flip ? -yw : yw;
      z_o  = flip ? HALF_TURN : '0;
    end
  end

endmodule

// File: rtl/cordic_pipe_stage.sv
module cordic_pipe_stage
  import cordic_pipe_pkg::*;
#(
  parameter int W   = 32,
  parameter int IW  = 38,
  parameter int IDX = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vld_i,
  input  cmode_e               mode_i,
  input  logic signed [IW-1:0] x_i,
  input  logic signed [IW-1:0] y_i,
  input  logic [W-1:0]         z_i,
  output logic                 vld_o,
  output cmode_e               mode_o,
  output logic signed [IW-1:0] x_o,
  output logic signed [IW-1:0] y_o,
  output logic [W-1:0]         z_o
);

  localparam logic [W-1:0] ATAN_STEP = W'(rescale(atan_turn32(IDX), W - 32));

  // Direction of this micro-rotation: counter-clockwise when the residual
  // angle is non-negative (rotation) or the vector lies below the axis.
  function automatic logic turn_ccw(input cmode_e m,
                                    input logic signed [IW-1:0] y,
                                    input logic [W-1:0] z);
    return (m == MODE_ROTATE) ? ($signed(z) >= 0) : (y < 0);
  endfunction

  logic                 ccw;
  logic signed [IW-1:0] x_sh, y_sh;
  logic signed [IW-1:0] x_nx, y_nx;
  logic [W-1:0]         z_nx;

  always_comb begin
    ccw  = turn_ccw(mode_i, y_i, z_i);
    x_sh = x_i >>> IDX;
    y_sh = y_i >>> IDX;
    if (ccw) begin
      x_nx = x_i - y_sh;
      y_nx = y_i + x_sh;
      z_nx = z_i - ATAN_STEP;
    end else begin
      x_nx = x_i + y_sh;
      y_nx = y_i - x_sh;
      z_nx = z_i + ATAN_STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_o <= 1'b0;
    else        vld_o <= vld_i;
  end

  always_ff @(posedge clk) begin
    if (vld_i) begin
      mode_o <= mode_i;
      x_o    <= x_nx;
      y_o    <= y_nx;
      z_o    <= z_nx;
    end
  end

endmodule

// File: rtl/cordic_pipe_trim.sv
module cordic_pipe_trim #(
  parameter int W     = 32,
  parameter int GUARD = 4,
  parameter int IW    = W + 2 + GUARD
) (
  input  logic signed [IW-1:0] x_i,
  input  logic signed [IW-1:0] y_i,
  output logic [W-1:0]         x_o,
  output logic [W-1:0]         y_o,
  output logic                 fits_o
);

  localparam logic signed [IW-1:0] HALF_LSB = IW'(1) <<< (GUARD - 1);

  // Round away the guard bits.
  function automatic logic [W-1:0] drop_guard(input logic signed [IW-1:0] v);
    return W'((v + HALF_LSB) >>> GUARD);
  endfunction

  // Value is representable in W output bits.
  function automatic logic in_range(input logic signed [IW-1:0] v);
    return ((v >>> (W + GUARD - 1)) == 0) || ((v >>> (W + GUARD - 1)) == -1);
  endfunction

  assign x_o    = drop_guard(x_i);
  assign y_o    = drop_guard(y_i);
  assign fits_o = in_range(x_i) && in_range(y_i);

endmodule

// File: rtl/cordic_pipe.sv
module cordic_pipe
  import cordic_pipe_pkg::*;
#(
  parameter int W     = 32,
  parameter int GUARD = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         in_mode,
  input  logic [W-1:0] in_x,
  input  logic [W-1:0] in_y,
  input  logic [W-1:0] in_angle,
  output logic         out_valid,
  output logic         out_mode,
  output logic [W-1:0] out_x,
  output logic [W-1:0] out_y,
  output logic [W-1:0] out_angle
);

  localparam int IW     = W + 2 + GUARD;
  localparam int STAGES = W;

  logic                 vld_p  [0:STAGES];
  cmode_e               mode_p [0:STAGES];
  logic signed [IW-1:0] x_p    [0:STAGES];
  logic signed [IW-1:0] y_p    [0:STAGES];
  logic [W-1:0]         z_p    [0:STAGES];

  // Named internal events for the checker.
  logic signed [IW-1:0] fold_x, fold_y;
  logic [W-1:0]         fold_z;
  logic                 out_fits;
  cmode_e               mode_in;

  assign mode_in = cmode_e'(in_mode);

  cordic_pipe_fold #(.W(W), .GUARD(GUARD), .IW(IW)) u_fold (
    .mode_i  (mode_in),
    .x_i     (in_x),
    .y_i     (in_y),
    .angle_i (in_angle),
    .x_o     (fold_x),
    .y_o     (fold_y),
    .z_o     (fold_z)
  );

  assign vld_p[0]  = in_valid;
  assign mode_p[0] = mode_in;
  assign x_p[0]    = fold_x;
  assign y_p[0]    = fold_y;
  assign z_p[0]    = fold_z;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    cordic_pipe_stage #(.W(W), .IW(IW), .IDX(k)) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld_i  (vld_p[k]),
      .mode_i (mode_p[k]),
      .x_i    (x_p[k]),
      .y_i    (y_p[k]),
      .z_i    (z_p[k]),
      .vld_o  (vld_p[k+1]),
      .mode_o (mode_p[k+1]),
      .x_o    (x_p[k+1]),
      .y_o    (y_p[k+1]),
      .z_o    (z_p[k+1])
    );
  end

  cordic_pipe_trim #(.W(W), .GUARD(GUARD), .IW(IW)) u_trim (
    .x_i    (x_p[STAGES]),
    .y_i    (y_p[STAGES]),
    .x_o    (out_x),
    .y_o    (out_y),
    .fits_o (out_fits)
  );

  assign out_valid = vld_p[STAGES];
  assign out_mode  = mode_p[STAGES];
  assign out_angle = z_p[STAGES];

endmodule

// File: rtl/cordic_pipe_chk.sv
module cordic_pipe_chk #(
  parameter int W      = 32,
  parameter int IW     = 38,
  parameter int STAGES = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_mode,
  input logic                 out_valid,
  input logic                 out_mode,
  input logic [W-1:0]         out_x,
  input logic [W-1:0]         out_y,
  input logic [W-1:0]         out_angle,
  input logic signed [IW-1:0] fold_x,
  input logic [W-1:0]         fold_z,
  input logic                 out_fits
);

  localparam logic signed [W-1:0] QUARTER = {2'b01, {(W-2){1'b0}}};

  // Independent record of what entered, one bit per clock in flight.
  logic [STAGES-1:0] vsr, msr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vsr <= '0;
      msr <= '0;
    end else begin
      vsr <= {vsr[STAGES-2:0], in_valid};
      msr <= {msr[STAGES-2:0], in_mode};
    end
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vsr[STAGES-1]);

  p_reset_quiet_r2: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  p_residual_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_mode) |-> ($signed(out_angle) < 256 && $signed(out_angle) > -256));

  p_fold_rot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_mode) |-> ($signed(fold_z) >= -QUARTER && $signed(fold_z) < QUARTER));

  p_vec_settled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_mode) |->
      ($signed(out_y) < 1024 && $signed(out_y) > -1024 && $signed(out_x) >= 0));

  p_fold_vec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode) |-> (fold_x >= 0));

  p_mode_carried_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mode == msr[STAGES-1]));

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_fits);

endmodule

bind cordic_pipe cordic_pipe_chk #(.W(W), .IW(IW), .STAGES(STAGES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_mode   (in_mode),
  .out_valid (out_valid),
  .out_mode  (out_mode),
  .out_x     (out_x),
  .out_y     (out_y),
  .out_angle (out_angle),
  .fold_x    (fold_x),
  .fold_z    (fold_z),
  .out_fits  (out_fits)
);

// File: tb/tb_cordic_pipe.sv
module tb_cordic_pipe;

  localparam int     CLK_PERIOD = 10;
  localparam int     LAT        = 32;
  localparam real    TWO_PI     = 6.283185307179586;
  localparam real    ONE_Q      = 1073741824.0;
  localparam real    TURN       = 4294967296.0;
  localparam real    GAIN       = 1.6467602581210656;
  localparam longint TOL        = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_mode = 1'b0;
  logic [31:0] in_x = '0, in_y = '0, in_angle = '0;
  logic        out_valid, out_mode;
  logic [31:0] out_x, out_y, out_angle;

  int n_cmp = 0;
  int n_bad = 0;
  int tag_now = 3;

  typedef struct {
    bit     vld;
    bit     mode;
    longint ex;
    longint ey;
    longint ez;
    int     tag;
  } exp_t;

  exp_t pipe_q[$];
  exp_t cur;
  bit   cur_ok = 1'b0;

  cordic_pipe dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_x(in_x), .in_y(in_y), .in_angle(in_angle),
    .out_valid(out_valid), .out_mode(out_mode),
    .out_x(out_x), .out_y(out_y), .out_angle(out_angle)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string req_name(input int t);
    case (t)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";  10: return "R10"; 11: return "R11";
      default: return "R?";
    endcase
  endfunction

  function automatic longint sx(input logic [31:0] v);
    return longint'($signed(v));
  endfunction

  function automatic longint labs(input longint v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic logic [31:0] q30(input real r);
    return 32'(longint'(r * ONE_Q));
  endfunction

  function automatic logic [31:0] deg(input real d);
    return 32'(longint'(d / 360.0 * TURN));
  endfunction

  // Real-number reference for one sample.
  function automatic exp_t make_exp(input bit rst_ok, input bit v, input bit m,
                                    input logic [31:0] x, input logic [31:0] y,
                                    input logic [31:0] a, input int tag);
    exp_t e;
    real th, fx, fy;
    e.vld  = rst_ok && v;
    e.mode = m;
    e.tag  = !rst_ok ? 2 : (!v ? 10 : tag);
    e.ex = 0; e.ey = 0; e.ez = 0;
    if (e.vld && !m) begin
      th   = real'(sx(a)) * TWO_PI / TURN;
      e.ex = longint'($cos(th) * ONE_Q);
      e.ey = longint'($sin(th) * ONE_Q);
    end else if (e.vld) begin
      fx   = real'(sx(x)) / ONE_Q;
      fy   = real'(sx(y)) / ONE_Q;
      e.ex = longint'(GAIN * $sqrt(fx * fx + fy * fy) * ONE_Q);
      e.ez = longint'($atan2(fy, fx) / TWO_PI * TURN);
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic check_out(input exp_t e);
    longint dz;
    check(out_valid == e.vld, e.vld ? "R1" : req_name(e.tag), "out_valid",
          longint'(out_valid), longint'(e.vld));
    if (e.vld && out_valid) begin
      check(out_mode == e.mode, "R9", "out_mode", longint'(out_mode), longint'(e.mode));
      check(labs(sx(out_x) - e.ex) <= TOL, req_name(e.tag), "out_x", sx(out_x), e.ex);
      check(labs(sx(out_y) - e.ey) <= TOL, req_name(e.tag), "out_y", sx(out_y), e.ey);
      dz = sx(out_angle - 32'(e.ez));
      check(labs(dz) <= TOL, e.mode ? req_name(e.tag) : "R4", "out_angle",
            sx(out_angle), e.ez);
    end
  endtask

  // Cycle model: one entry per rising edge, the entry LAT edges old is due now.
  always @(posedge clk) begin
    pipe_q.push_back(make_exp(rst_n, in_valid, in_mode, in_x, in_y, in_angle, tag_now));
    if (pipe_q.size() == LAT) begin
      cur    = pipe_q.pop_front();
      cur_ok = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (cur_ok) check_out(cur);
  end

  task automatic drive(input bit v, input bit m, input logic [31:0] x,
                       input logic [31:0] y, input logic [31:0] a, input int tag);
    in_valid = v; in_mode = m; in_x = x; in_y = y; in_angle = a; tag_now = tag;
    @(negedge clk);
  endtask

  task automatic rot(input logic [31:0] a, input int tag);
    drive(1'b1, 1'b0, $urandom, $urandom, a, tag);
  endtask

  task automatic vec(input real x, input real y, input int tag);
    drive(1'b1, 1'b1, q30(x), q30(y), $urandom, tag);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    // R2: quiet output during reset
    repeat (4) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R2", "out_valid in reset", longint'(out_valid), 0);
    end
    rst_n = 1'b1;

    // R3: angles inside the half plane
    rot(deg(0.0), 3);   rot(deg(30.0), 3);  rot(deg(-45.0), 3);
    rot(deg(60.0), 3);  rot(deg(-89.9), 3); rot(32'h00000100, 3);

    // R5: quadrant edges and folded quadrants
    rot(32'h40000000, 5); rot(32'h80000000, 5); rot(32'hBFFFFFFF, 5);
    rot(deg(135.0), 5);   rot(deg(-135.0), 5);  rot(32'h3FFFFFFF, 5);

    // R6: same angle, unrelated x/y operands
    drive(1'b1, 1'b0, 32'h7FFFFFFF, 32'h80000000, deg(20.0), 6);
    drive(1'b1, 1'b0, 32'h00000000, 32'h12345678, deg(20.0), 6);

    // R7: right half plane vectors, including the positive y axis
    vec(0.5, 0.3, 7);  vec(0.2, -0.7, 7);  vec(0.0, 0.6, 7);  vec(0.9, 0.0, 7);

    // R8: left half plane, including the negative x axis
    vec(-0.5, 0.2, 8); vec(-0.6, 0.0, 8);  vec(-0.3, -0.4, 8); vec(-0.01, 0.7, 8);

    // R11: near the length limit
    vec(0.99, 0.0, 11); vec(-0.7, 0.7, 11);

    // R9: mode flips every clock
    for (int i = 0; i < 20; i++) begin
      if (i % 2 == 0) rot(deg(17.0 * i - 170.0), 9);
      else vec(0.6 * $cos(i * 0.7), 0.6 * $sin(i * 0.7), 9);
    end

    // R10: bubbles carrying garbage between valid samples
    for (int i = 0; i < 12; i++) begin
      drive(1'b0, i[0], $urandom, $urandom, $urandom, 10);
      if (i % 3 == 0) rot($urandom, 10);
    end

    // R1: long back-to-back stream
    for (int i = 0; i < 64; i++) rot($urandom, 1);

    // Random mixed sweep
    for (int i = 0; i < 300; i++) begin
      real d, m;
      d = $urandom_range(0, 359999) / 1000.0;
      m = 0.25 + $urandom_range(0, 700) / 1000.0;
      if ($urandom_range(0, 1) == 1) vec(m * $cos(d * TWO_PI / 360.0), m * $sin(d * TWO_PI / 360.0), 7);
      else rot($urandom, 3);
      if ($urandom_range(0, 7) == 0) drive(1'b0, 1'b0, $urandom, $urandom, $urandom, 10);
    end

    // Drain
    repeat (LAT + 4) drive(1'b0, 1'b0, '0, '0, '0, 10);
    summary();
    $finish;
  end

endmodule